// File: doc/BRIEF.md
# Synchronous NOR Burst Read Controller

This block reads bursts from a NOR-style flash that runs in synchronous mode. A host places a start address and a burst-length code on a request/ready port. The block then drives the flash chip select, a one-cycle address-valid strobe, output enable and the address. It counts a programmable initial latency, captures one data word on every clock edge for the whole burst, and streams each word to the host with a valid flag. After the last word it keeps chip select and output enable low for a programmable completion period. It then releases them and signals completion with a one-cycle done pulse.

Every timing value is a whole number of cycles of the interface clock. The flash clock output is a free-running copy of that clock. The initial latency must cover the clock start-up, the device access time and a data-setup margin. At the nominal interface rate this is nine cycles, which is the reset value. Burst writes and the reserved length code are refused. A refusal raises an error pulse and causes no memory activity. Latency and completion length are held in two configuration registers. The host may rewrite them only while the controller is idle.

Top module: `nbr_ctrl`

## Requirements
- R1: After reset, req_ready is 1; mem_cs_n, mem_adv_n and mem_oe_n are 1; rd_valid, done and req_err are 0. The latency register holds 9 and the completion register holds 1.
- R2: A read is accepted at a clock edge where req_valid and req_ready are both 1, req_write is 0 and req_len is not 3. In the cycle after that edge, mem_cs_n and mem_adv_n are 0. mem_adv_n is 0 for exactly that one cycle. mem_addr equals the accepted req_addr for as long as mem_cs_n stays 0.
- R3: mem_oe_n is 0 from the second cycle of the access to the last cycle in which mem_cs_n is 0. It is never 0 while mem_cs_n is 1.
- R4: Let L be the latency register value, with values below 2 treated as 2. The first word is sampled from mem_dq at the L-th clock edge after the accept edge. rd_valid is 1 in the cycle after each sample edge, and rd_data then holds the word sampled at that edge.
- R5: The req_len code gives the burst length: 0 is 4 words, 1 is 8 words, 2 is 16 words. The words are sampled on consecutive edges with no gap.
- R6: Let H be the completion register value, with 0 treated as 1. mem_cs_n and mem_oe_n return to 1 at the H-th edge after the last sample edge.
- R7: done is 1 for exactly one cycle, starting one cycle after mem_cs_n returns to 1. req_ready is 0 from the accept edge until it returns to 1 in the same cycle as done.
- R8: A request with req_write equal to 1 is refused. req_err is 1 for one cycle after that edge, mem_cs_n stays 1, no word and no done are produced, and req_ready stays 1.
- R9: A read request with req_len equal to 3 is refused in the same way as a write.
- R10: When cfg_we is 1 at an edge while the block is idle, the latency and completion registers take cfg_lat_wdata and cfg_hold_wdata. While a burst is in progress, cfg_we has no effect.
- R11: mem_clk follows clk at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing registers |
| cfg_lat_wdata | input | LAT_W | New initial latency in cycles |
| cfg_hold_wdata | input | HOLD_W | New completion hold in cycles |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | Request is a burst write (refused) |
| req_len | input | 2 | Burst length code: 0=4, 1=8, 2=16, 3 reserved |
| req_addr | input | ADDR_W | Burst start address |
| req_ready | output | 1 | Controller idle and able to accept |
| req_err | output | 1 | One-cycle pulse for a refused request |
| mem_clk | output | 1 | Free-running flash clock |
| mem_cs_n | output | 1 | Flash chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Address to the flash |
| mem_dq | input | DATA_W | Data from the flash |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DATA_W | Captured word |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
Each result is counted in edges from the accept edge e0. The strobes change at e0. The first valid word appears at e0+L. The last word appears at e0+L+N-1. Chip select rises at e0+L+N-1+H and done follows one edge later. An error pulse appears at e0. The bench reads the edge counter and samples all outputs at the falling edge after each rising edge, so each observation belongs to exactly one edge. It then compares the recorded edge numbers with these formulas, and it checks each word against the pattern the flash model drove for that edge.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_BURST,
        ST_HOLD,
        ST_REL
    } nbr_state_e;

    typedef struct packed {
        logic cs_n;
        logic adv_n;
        logic oe_n;
    } nbr_strb_t;

    localparam int LAT_DEFAULT  = 9;
    localparam int HOLD_DEFAULT = 1;
    localparam int LAT_MIN      = 2;
    localparam int HOLD_MIN     = 1;

    localparam logic [1:0] LEN_RSVD = 2'd3;

    // beat count for a length code; 0 for the reserved code
    function automatic logic [4:0] beats_of(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd4;
            2'd1:    return 5'd8;
            2'd2:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic len_ok(input logic [1:0] code);
        return code != LEN_RSVD;
    endfunction

    function automatic nbr_strb_t strobes_of(input nbr_state_e st);
        nbr_strb_t s;
        s = '{cs_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1};
        case (st)
            ST_ADDR:                   s = '{cs_n: 1'b0, adv_n: 1'b0, oe_n: 1'b1};
            ST_WAIT, ST_BURST, ST_HOLD: s = '{cs_n: 1'b0, adv_n: 1'b1, oe_n: 1'b0};
            default:                   s = '{cs_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nbr_cnt.sv
module nbr_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec && cnt_q != '0) cnt_q <= cnt_q - W'(1);
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == W'(1));
endmodule

// File: rtl/nbr_cfg.sv
module nbr_cfg #(
    parameter int LAT_W  = 5,
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              allow,
    input  logic [LAT_W-1:0]  lat_in,
    input  logic [HOLD_W-1:0] hold_in,
    output logic [LAT_W-1:0]  lat_eff,
    output logic [HOLD_W-1:0] hold_eff
);
    import nbr_pkg::*;

    logic [LAT_W-1:0]  lat_q;
    logic [HOLD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q  <= LAT_W'(LAT_DEFAULT);
            hold_q <= HOLD_W'(HOLD_DEFAULT);
        end else if (we && allow) begin
            lat_q  <= lat_in;
            hold_q <= hold_in;
        end
    end

    // raise too-small settings to the shortest legal sequence
    assign lat_eff  = (lat_q  < LAT_W'(LAT_MIN))   ? LAT_W'(LAT_MIN)   : lat_q;
    assign hold_eff = (hold_q < HOLD_W'(HOLD_MIN)) ? HOLD_W'(HOLD_MIN) : hold_q;
endmodule

// File: rtl/nbr_capture.sv
module nbr_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] dq,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= take;
            if (take) out_data <= dq;
        end
    end
endmodule

// File: rtl/nbr_ctrl.sv
module nbr_ctrl #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int LAT_W  = 5,
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [LAT_W-1:0]  cfg_lat_wdata,
    input  logic [HOLD_W-1:0] cfg_hold_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_len,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              req_err,
    output logic              mem_clk,
    output logic              mem_cs_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    import nbr_pkg::*;

    localparam int CW0   = (LAT_W > HOLD_W) ? LAT_W : HOLD_W;
    localparam int CNT_W = (CW0 > 5) ? CW0 : 5;

    nbr_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        len_q;
    logic              err_q, done_q;

    logic [LAT_W-1:0]  lat_eff;
    logic [HOLD_W-1:0] hold_eff;

    logic              cnt_load, cnt_dec, cnt_zero, cnt_one;
    logic [CNT_W-1:0]  cnt_val;
    logic              take;

    logic idle, start, refuse;
    nbr_strb_t strb;

    assign idle   = (state_q == ST_IDLE);
    assign start  = idle && req_valid && !req_write && len_ok(req_len);
    assign refuse = idle && req_valid && !(!req_write && len_ok(req_len));

    nbr_cfg #(.LAT_W(LAT_W), .HOLD_W(HOLD_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .allow    (idle),
        .lat_in   (cfg_lat_wdata),
        .hold_in  (cfg_hold_wdata),
        .lat_eff  (lat_eff),
        .hold_eff (hold_eff)
    );

    nbr_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    nbr_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .dq        (mem_dq),
        .out_valid (rd_valid),
        .out_data  (rd_data)
    );

    // one shared counter walks latency, beats and hold in turn
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        take     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_ADDR;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(lat_eff) - CNT_W'(1);
                end
            end
            ST_ADDR: begin
                state_d = ST_WAIT;
                cnt_dec = 1'b1;
            end
            ST_WAIT: begin
                if (cnt_zero) begin
                    take     = 1'b1;
                    state_d  = ST_BURST;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(beats_of(len_q)) - CNT_W'(1);
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_BURST: begin
                take = 1'b1;
                if (cnt_one) begin
                    state_d  = ST_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(hold_eff) - CNT_W'(1);
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) state_d = ST_REL;
                else          cnt_dec = 1'b1;
            end
            ST_REL:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            len_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= refuse;
            done_q  <= (state_q == ST_REL);
            if (start) begin
                addr_q <= req_addr;
                len_q  <= req_len;
            end
        end
    end

    assign strb      = strobes_of(state_q);
    assign mem_cs_n  = strb.cs_n;
    assign mem_adv_n = strb.adv_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_addr  = addr_q;
    assign mem_clk   = clk;
    assign req_ready = idle;
    assign req_err   = err_q;
    assign done      = done_q;
endmodule

// File: rtl/nbr_ctrl_chk.sv
module nbr_ctrl_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_len,
    input logic              req_ready,
    input logic              req_err,
    input logic              mem_cs_n,
    input logic              mem_adv_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_valid,
    input logic              done
);
    AST_ACCEPT_STROBES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write && req_len != 2'd3) |=> (!mem_cs_n && !mem_adv_n)); // R2
    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |=> mem_adv_n); // R2
    AST_ADV_IN_CS: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> !mem_cs_n); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R2
    AST_OE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_cs_n); // R3
    AST_VALID_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(mem_oe_n)); // R4
    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_cs_n && $past(mem_cs_n) && !$past(mem_cs_n, 2))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_cs_n); // R7
    AST_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_write || req_len == 2'd3)) |=> (req_err && mem_cs_n)); // R8 R9
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_err |=> !req_err); // R8
endmodule

bind nbr_ctrl nbr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_len   (req_len),
    .req_ready (req_ready),
    .req_err   (req_err),
    .mem_cs_n  (mem_cs_n),
    .mem_adv_n (mem_adv_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .rd_valid  (rd_valid),
    .done      (done)
);

// File: tb/nbr_ctrl_bench.sv
module nbr_ctrl_bench;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int LW = 5;
    localparam int HW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [LW-1:0] cfg_lat_wdata;
    logic [HW-1:0] cfg_hold_wdata;
    logic          req_valid, req_write;
    logic [1:0]    req_len;
    logic [AW-1:0] req_addr;
    logic          req_ready, req_err, mem_clk, mem_cs_n, mem_adv_n, mem_oe_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq;
    logic          rd_valid, done;
    logic [DW-1:0] rd_data;

    int ecnt = 0;
    int checks = 0;
    int fails = 0;
    int cur_lat = 9;
    int cur_hold = 1;

    always #10 clk = ~clk;
    always @(posedge clk) ecnt <= ecnt + 1;
    // word sampled at edge m carries (m-1)*7+3
    always @(negedge clk) mem_dq <= DW'(ecnt * 7 + 3);

    nbr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAT_W(LW), .HOLD_W(HW)) u_nbr_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lat_wdata(cfg_lat_wdata),
        .cfg_hold_wdata(cfg_hold_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .req_addr(req_addr), .req_ready(req_ready), .req_err(req_err),
        .mem_clk(mem_clk), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done)
    );

    // {write, len[1:0], lat[4:0], hold[2:0]}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 2'd0, 5'd9,  3'd1},
        {1'b0, 2'd1, 5'd4,  3'd3},
        {1'b0, 2'd2, 5'd2,  3'd0},
        {1'b1, 2'd0, 5'd2,  3'd0},
        {1'b0, 2'd3, 5'd2,  3'd0},
        {1'b0, 2'd0, 5'd1,  3'd2},
        {1'b0, 2'd2, 5'd31, 3'd7},
        {1'b0, 2'd1, 5'd0,  3'd1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int lat, input int hold);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_lat_wdata = LW'(lat);
        cfg_hold_wdata = HW'(hold);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_lat = lat;
        cur_hold = hold;
    endtask

    task automatic run_txn(input bit wr, input logic [1:0] len, input logic [AW-1:0] addr,
                           input bit poke);
        int e0, n;
        int cs_first = -1, cs_rise = -1, adv_cnt = 0, adv_edge = -1;
        int oe_first = -1, oe_last = -1, rd_first = -1, rd_last = -1, beats = 0, gaps = 0;
        int data_bad = 0, addr_bad = 0, done_edge = -1, done_cnt = 0;
        int err_edge = -1, err_cnt = 0, rdy_bad = 0, mclk_bad = 0;
        bit refused;
        int nb, el, eh;
        refused = wr || (len == 2'd3);
        nb = 4 << len;
        el = (cur_lat < 2) ? 2 : cur_lat;
        eh = (cur_hold < 1) ? 1 : cur_hold;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_len = len;
        req_addr = addr;
        @(negedge clk);
        e0 = ecnt;
        for (int k = 0; k < 80; k++) begin
            if (k > 0) @(negedge clk);
            n = ecnt;
            if (mem_clk !== 1'b0) mclk_bad++;
            if (!mem_cs_n && cs_rise < 0) begin
                if (cs_first < 0) cs_first = n;
                if (mem_addr !== addr) addr_bad++;
            end
            if (mem_cs_n && cs_first >= 0 && cs_rise < 0) cs_rise = n;
            if (!mem_adv_n) begin adv_cnt++; adv_edge = n; end
            if (!mem_oe_n) begin
                if (oe_first < 0) oe_first = n;
                oe_last = n;
            end
            if (rd_valid) begin
                beats++;
                if (rd_first < 0) rd_first = n;
                else if (n != rd_last + 1) gaps++;
                rd_last = n;
                if (rd_data !== DW'((n - 1) * 7 + 3)) data_bad++;
            end
            if (done) begin done_cnt++; if (done_edge < 0) done_edge = n; end
            if (req_err) begin err_cnt++; if (err_edge < 0) err_edge = n; end
            if (refused) begin
                if (!req_ready) rdy_bad++;
            end else begin
                if (done_edge < 0 && req_ready) rdy_bad++;
                if (n == done_edge && !req_ready) rdy_bad++;
            end
            if (k == 0) req_valid = 1'b0;
            if (poke && k == 3) begin
                cfg_we = 1'b1; cfg_lat_wdata = LW'(20); cfg_hold_wdata = HW'(6);
            end
            if (poke && k == 4) cfg_we = 1'b0;
        end
        chk(mclk_bad == 0, "R11", "mem_clk low at falling edge", mclk_bad, 0);
        if (refused) begin
            chk(err_edge == e0 && err_cnt == 1, wr ? "R8" : "R9", "error pulse edge", err_edge, e0);
            chk(cs_first == -1 && beats == 0, wr ? "R8" : "R9", "memory cycle started", cs_first, -1);
            chk(done_cnt == 0 && rdy_bad == 0, wr ? "R8" : "R9", "done/ready disturbed", done_cnt + rdy_bad, 0);
        end else begin
            chk(cs_first == e0, "R2", "cs_n fall edge", cs_first, e0);
            chk(adv_cnt == 1 && adv_edge == e0, "R2", "adv_n pulse edge", adv_edge, e0);
            chk(addr_bad == 0, "R2", "address mismatches", addr_bad, 0);
            chk(oe_first == e0 + 1, "R3", "oe_n fall edge", oe_first, e0 + 1);
            chk(oe_last == cs_rise - 1, "R3", "last oe_n low edge", oe_last, cs_rise - 1);
            chk(rd_first == e0 + el, "R4", "first word edge", rd_first, e0 + el);
            chk(data_bad == 0, "R4", "data mismatches", data_bad, 0);
            chk(beats == nb && gaps == 0, "R5", "beat count", beats, nb);
            chk(cs_rise == e0 + el + nb - 1 + eh, "R6", "cs_n rise edge", cs_rise, e0 + el + nb - 1 + eh);
            chk(done_edge == cs_rise + 1 && done_cnt == 1, "R7", "done edge", done_edge, cs_rise + 1);
            chk(rdy_bad == 0, "R7", "ready errors", rdy_bad, 0);
            chk(err_cnt == 0, "R8", "spurious error", err_cnt, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_we = 1'b0;
        cfg_lat_wdata = '0;
        cfg_hold_wdata = '0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_len = 2'd0;
        req_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);
        chk({mem_cs_n, mem_adv_n, mem_oe_n} === 3'b111, "R1", "strobes", {mem_cs_n, mem_adv_n, mem_oe_n}, 7);
        chk({rd_valid, done, req_err} === 3'b000, "R1", "valid/done/err", {rd_valid, done, req_err}, 0);

        // vector table; first entry relies on the reset defaults 9 and 1 (R1)
        for (int i = 0; i < 8; i++) begin
            if (int'(VEC[i][7:3]) != cur_lat || int'(VEC[i][2:0]) != cur_hold)
                cfg_write(int'(VEC[i][7:3]), int'(VEC[i][2:0]));   // R10 idle write
            run_txn(VEC[i][10], VEC[i][9:8], AW'(24'h10_0000 + i * 24'h0123), 1'b0);
        end

        // R10: write while busy is ignored; next read keeps 5 and 2
        cfg_write(5, 2);
        run_txn(1'b0, 2'd0, AW'(24'hABCDE0), 1'b1);
        run_txn(1'b0, 2'd1, AW'(24'h00F00D), 1'b0);

        // R8 after a read, then a read proves the refusal left no trace
        run_txn(1'b1, 2'd2, AW'(24'h555555), 1'b0);
        run_txn(1'b0, 2'd2, AW'(24'hFFFFFF), 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule